// File: doc/BRIEF.md
# Handshake-Terminated Bus Cycle Sequencer

This block is the master end of an external bus on which the addressed device ends each transfer with a handshake instead of answering within a fixed time. A local client offers one read or write request at a time. The sequencer first places the address and transfer size on the bus. It then asserts direction, the address strobe and the data strobe. After that it waits as long as the device needs. The device ends the cycle with an active-low acknowledge code that also gives its port width, or with a bus-error input. A halt input may come with the error, and the error may arrive up to one bus clock after the acknowledge.

The sequencer runs on a clock at twice the bus rate, so each internal clock is one half-period state. It produces the bus clock itself by toggling every internal clock, and a cycle always begins while that clock is high. Termination inputs pass through a synchronizer before they are used. Read data is captured one bus clock after the acknowledge is recognized. The strobes are negated next, and a one-clock done pulse then carries the status, the acknowledged port width and the read data back to the client.

Top module: `hsb_master`

## Requirements
- R1: After synchronous reset, bus_as_n, bus_ds_n and bus_rw_n are 1, bus_doe is 0, and done is 0.
- R2: On the clock after a request is accepted, bus_addr and bus_size carry the request while bus_as_n is still 1. The strobes are asserted one clock later. Address and size stay stable while bus_as_n is 0. bus_rw_n is 1 for a read and 0 for a write, and a write drives bus_dout with bus_doe at 1.
- R3: The acknowledge code on bus_ack_n is active low: 00 means a 32-bit port, 01 a 16-bit port, 10 an 8-bit port, and 11 means keep waiting. The recognized code is returned on done_port.
- R4: If the synchronized acknowledge is already present at the first sample point, done rises 6 internal clocks (3 bus clocks) after the accepting edge.
- R5: Each sample point that finds no termination adds two internal clocks, with no upper limit. Sample points fall on the 3rd, 5th, 7th and later internal clocks after acceptance. An input driven in the interval after internal clock j is first seen on clock j+3.
- R6: For a read, bus_din is captured one bus clock (two internal clocks) after the recognized acknowledge, not on the recognizing edge.
- R7: done_status is 00 for normal completion, 01 for a bus error, and 10 for a retry (bus error with halt). The bus-error and halt levels are taken at the capture point, so an error asserted after the acknowledge still overrides. A bus error with no acknowledge also terminates the cycle.
- R8: Halt asserted alone neither terminates the cycle nor changes the status.
- R9: bus_as_n and bus_ds_n are negated one internal clock before done, and done is high for exactly one clock.
- R10: A request is accepted only while idle and bus_clk is 0. req_ready is 0 for the whole of a cycle.
- R11: bus_clk toggles on every internal clock and is 1 in the first state of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a request |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock completion pulse |
| done_status | output | 2 | 00 ok, 01 bus error, 10 retry |
| done_port | output | 2 | Acknowledged port-width code |
| done_rdata | output | DATA_W | Captured read data |
| bus_clk | output | 1 | Generated bus clock |
| bus_addr | output | ADDR_W | Bus address |
| bus_size | output | 2 | Bus size code |
| bus_rw_n | output | 1 | 1 read, 0 write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_dout | output | DATA_W | Write data to bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from bus |
| bus_ack_n | input | 2 | Acknowledge / port-width code, active low |
| bus_berr_n | input | 1 | Bus error, active low |
| bus_halt_n | input | 1 | Halt, active low |

## Verification
The hardest case to reach is an error that comes after the acknowledge. The error must fall after the recognizing edge yet still be seen through the synchronizer by the capture edge. The bench's device model therefore times every input in falling edges counted from the first falling edge on which it sees the address strobe low. It asserts the acknowledge at one offset, the error one edge later, and valid read data two edges later, with junk on the data bus before that. Zero-wait cycles need the acknowledge to be present before the strobe, so the model can also pre-assert it before the request is offered.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_WL   = 4'd4,
        ST_WH   = 4'd5,
        ST_S3   = 4'd6,
        ST_S4   = 4'd7,
        ST_S5   = 4'd8
    } hsb_state_e;

    typedef enum logic [1:0] {
        STS_OK    = 2'b00,
        STS_BERR  = 2'b01,
        STS_RETRY = 2'b10
    } hsb_sts_e;

    localparam logic [1:0] ACK_WAIT = 2'b11;

    // a sample point ends the wait when any port code or a bus error is present
    function automatic logic hsb_is_term(input logic [1:0] ack_n, input logic berr_n);
        return (ack_n != ACK_WAIT) || !berr_n;
    endfunction

    function automatic hsb_sts_e hsb_status(input logic berr_n, input logic halt_n);
        if (berr_n)
            return STS_OK;
        else if (!halt_n)
            return STS_RETRY;
        else
            return STS_BERR;
    endfunction

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[g] <= '1;
            else if (g == 0)
                chain[g] <= d;
            else
                chain[g] <= chain[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
    import hsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    output logic       req_ready,
    output logic       accept,
    output logic       capture,
    input  logic [1:0] ack_s,
    input  logic       berr_s,
    input  logic       halt_s,
    output logic       done,
    output hsb_sts_e   status,
    output logic [1:0] port,
    output logic       bus_clk,
    output logic       as_n,
    output logic       ds_n,
    output logic       rw_n,
    output logic       doe
);
    hsb_state_e st, st_nx;
    logic       wr_q;
    logic       term;

    assign term      = hsb_is_term(ack_s, berr_s);
    assign req_ready = (st == ST_IDLE) && !bus_clk;
    assign accept    = req_ready && req_valid;
    assign capture   = (st == ST_S4) && !wr_q;

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (accept) st_nx = ST_S0;
            ST_S0:   st_nx = ST_S1;
            ST_S1:   st_nx = ST_S2;
            ST_S2,
            ST_WH:   st_nx = term ? ST_S3 : ST_WL;
            ST_WL:   st_nx = ST_WH;
            ST_S3:   st_nx = ST_S4;
            ST_S4:   st_nx = ST_S5;
            ST_S5:   st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bus_clk <= 1'b0;
            wr_q    <= 1'b0;
            as_n    <= 1'b1;
            ds_n    <= 1'b1;
            rw_n    <= 1'b1;
            doe     <= 1'b0;
            done    <= 1'b0;
            status  <= STS_OK;
            port    <= ACK_WAIT;
        end else begin
            st      <= st_nx;
            bus_clk <= ~bus_clk;
            done    <= (st == ST_S5);
            if (accept)
                wr_q <= req_write;
            if (st == ST_S0) begin
                as_n <= 1'b0;
                ds_n <= 1'b0;
                rw_n <= ~wr_q;
                doe  <= wr_q;
            end
            if ((st == ST_S2 || st == ST_WH) && term)
                port <= ack_s;
            if (st == ST_S4) begin
                as_n   <= 1'b1;
                ds_n   <= 1'b1;
                rw_n   <= 1'b1;
                doe    <= 1'b0;
                status <= hsb_status(berr_s, halt_s);
            end
        end
    end

    a_r11_clk_toggles: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bus_clk != $past(bus_clk)));

    a_r10_accept_to_s0: assert property (@(posedge clk) disable iff (rst)
        accept |=> (st == ST_S0) && bus_clk && !req_ready);

    a_r9_strobes_before_done: assert property (@(posedge clk) disable iff (rst)
        done |-> as_n && ds_n && $past(as_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_status_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> (logic'(status == STS_OK) || logic'(status == STS_BERR) || logic'(status == STS_RETRY)));
endmodule

// File: rtl/hsb_master.sv
module hsb_master
    import hsb_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [1:0]        done_port,
    output logic [DATA_W-1:0] done_rdata,
    output logic              bus_clk,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_rw_n,
    output logic              bus_as_n,
    output logic              bus_ds_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [1:0]        bus_ack_n,
    input  logic              bus_berr_n,
    input  logic              bus_halt_n
);
    localparam int TERM_W = 4;

    logic [TERM_W-1:0] term_raw, term_s;
    logic              accept, capture;
    hsb_sts_e          sts;

    assign term_raw = {bus_halt_n, bus_berr_n, bus_ack_n};

    hsb_sync #(.W(TERM_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (term_raw),
        .q   (term_s)
    );

    hsb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .ack_s     (term_s[1:0]),
        .berr_s    (term_s[2]),
        .halt_s    (term_s[3]),
        .done      (done),
        .status    (sts),
        .port      (done_port),
        .bus_clk   (bus_clk),
        .as_n      (bus_as_n),
        .ds_n      (bus_ds_n),
        .rw_n      (bus_rw_n),
        .doe       (bus_doe)
    );

    assign done_status = sts;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr   <= '0;
            bus_size   <= '0;
            bus_dout   <= '0;
            done_rdata <= '0;
        end else begin
            if (accept) begin
                bus_addr <= req_addr;
                bus_size <= req_size;
                bus_dout <= req_wdata;
            end
            if (capture)
                done_rdata <= bus_din;
        end
    end

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_size)));

    a_r2_strobe_after_addr: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_as_n) |-> $past(accept, 2));
endmodule

// File: tb/hsb_master_tb_top.sv
module hsb_master_tb_top;
    localparam int AW = 24;
    localparam int DW = 32;

    typedef struct {
        logic [1:0]    sts;
        logic [1:0]    port;
        logic          rd;
        logic [DW-1:0] data;
        int            lat;
        int            acc;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] bus_din = '0;
    logic [1:0] bus_ack_n = 2'b11;
    logic bus_berr_n = 1'b1, bus_halt_n = 1'b1;
    logic req_ready, done, bus_clk, bus_rw_n, bus_as_n, bus_ds_n, bus_doe;
    logic [1:0] done_status, done_port, bus_size;
    logic [DW-1:0] done_rdata, bus_dout;
    logic [AW-1:0] bus_addr;

    int checks = 0, errors = 0, cyc = 0;
    exp_t sb[$];

    // device model configuration for the current transfer
    logic [1:0] c_ack;
    int c_dack, c_dberr, c_dhalt, c_ddata;
    bit c_pre;
    logic [DW-1:0] c_data;
    logic c_wr;
    logic [AW-1:0] c_addr;
    logic [1:0] c_size;
    logic [DW-1:0] c_wdata;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hsb_master dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .done(done), .done_status(done_status),
        .done_port(done_port), .done_rdata(done_rdata), .bus_clk(bus_clk),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_rw_n(bus_rw_n),
        .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack_n(bus_ack_n),
        .bus_berr_n(bus_berr_n), .bus_halt_n(bus_halt_n)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // device: times every input from the first falling edge with the strobe low
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !bus_as_n) begin
                chk(bus_addr == c_addr && bus_size == c_size, "R2 address/size", {bus_size, bus_addr}, {c_size, c_addr});
                chk(bus_rw_n == ~c_wr, "R2 direction", bus_rw_n, ~c_wr);
                if (c_wr)
                    chk(bus_doe && bus_dout == c_wdata, "R2 write data", bus_dout, c_wdata);
                if (!c_pre) begin
                    bus_din = 32'hBAD0_BAD0;
                    for (int t = 0; t <= c_ddata; t++) begin
                        if (t == c_dack)  bus_ack_n  = c_ack;
                        if (t == c_dberr) bus_berr_n = 1'b0;
                        if (t == c_dhalt) bus_halt_n = 1'b0;
                        if (t == c_ddata) bus_din    = c_data;
                        if (t < c_ddata) @(negedge clk);
                    end
                end
                while (!bus_as_n) @(negedge clk);
                bus_ack_n  = 2'b11;
                bus_berr_n = 1'b1;
                bus_halt_n = 1'b1;
                bus_din    = 32'h5A5A_5A5A;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                chk(bus_as_n && bus_ds_n, "R9 strobes negated at done", {bus_as_n, bus_ds_n}, 2'b11);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(done_status == e.sts, "R7 status", done_status, e.sts);
                    chk(done_port == e.port, "R3 port code", done_port, e.port);
                    chk(cyc - e.acc == e.lat, "R4/R5 latency", cyc - e.acc, e.lat);
                    if (e.rd)
                        chk(done_rdata == e.data, "R6 read data", done_rdata, e.data);
                end
                @(negedge clk);
                chk(!done, "R9 done single pulse", done, 0);
            end
        end
    end

    // driver: configures the device, offers the request, pushes the expectation
    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [DW-1:0] wd, input logic [1:0] ack, input int d,
                        input bit pre, input int dberr, input bit halt_w_berr,
                        input int dhalt, input logic [DW-1:0] rd);
        exp_t e;
        int term, k;
        c_wr = wr; c_addr = a; c_size = sz; c_wdata = wd; c_ack = ack;
        c_pre = pre; c_data = rd;
        c_dack  = (ack != 2'b11) ? d : -1;
        c_dberr = dberr;
        c_dhalt = halt_w_berr ? dberr : dhalt;
        term    = (ack != 2'b11) ? d : dberr;
        c_ddata = term + 2;
        k = pre ? 0 : (term + 2) / 2;
        e.sts  = (dberr >= 0) ? (halt_w_berr ? 2'b10 : 2'b01) : 2'b00;
        e.port = ack;
        e.rd   = !wr;
        e.data = rd;
        e.lat  = 6 + 2 * k;
        if (pre) begin
            bus_ack_n = ack;
            bus_din   = rd;
            repeat (3) @(negedge clk);
        end
        req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        e.acc = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_addr == a && bus_as_n, "R2 address before strobe", {bus_as_n, bus_addr}, {1'b1, a});
        chk(bus_clk == 1'b1, "R11 bus clock high in first state", bus_clk, 1);
        chk(!req_ready, "R10 not ready while busy", req_ready, 0);
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_as_n && bus_ds_n && bus_rw_n, "R1 strobes idle after reset", {bus_as_n, bus_ds_n, bus_rw_n}, 3'b111);
        chk(!done && !bus_doe, "R1 done and drive off", {done, bus_doe}, 0);
        begin
            logic b0;
            b0 = bus_clk;
            @(negedge clk);
            chk(bus_clk != b0, "R11 bus clock toggles", bus_clk, ~b0);
        end
        // R4 zero wait, 32-bit port, acknowledge already present
        xfer(1'b0, 24'h00_1234, 2'b00, '0, 2'b00, 0, 1'b1, -1, 1'b0, -1, 32'hCAFE_0001);
        // R5 one wait state, 16-bit port, R6 data late
        xfer(1'b0, 24'h12_0002, 2'b10, '0, 2'b01, 0, 1'b0, -1, 1'b0, -1, 32'h1111_2222);
        // R5 write, 8-bit port, two wait states
        xfer(1'b1, 24'hAB_CDEF, 2'b01, 32'hDEAD_BEEF, 2'b10, 3, 1'b0, -1, 1'b0, -1, 32'h0);
        // R5 long wait
        xfer(1'b0, 24'h00_0F00, 2'b00, '0, 2'b00, 20, 1'b0, -1, 1'b0, -1, 32'h7654_3210);
        // R7 bus error one edge after acknowledge
        xfer(1'b0, 24'h33_3330, 2'b11, '0, 2'b01, 0, 1'b0, 1, 1'b0, -1, 32'h0BAD_F00D);
        // R7 retry: error with halt after acknowledge, write
        xfer(1'b1, 24'h44_4440, 2'b00, 32'h0102_0304, 2'b00, 2, 1'b0, 3, 1'b1, -1, 32'h0);
        // R7 bus error with no acknowledge
        xfer(1'b0, 24'h55_5550, 2'b00, '0, 2'b11, 0, 1'b0, 2, 1'b0, -1, 32'h9999_8888);
        // R8 halt alone keeps waiting, status normal
        xfer(1'b0, 24'h66_6660, 2'b00, '0, 2'b10, 4, 1'b0, -1, 1'b0, 0, 32'hA5A5_0F0F);
        chk(sb.size() == 0, "R9 all completions seen", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule